// File: doc/BRIEF.md
# Whole-Message Kernel Mailbox over AXI4

This block connects a host's AXI4 slave port to a compute kernel. The host writes one fixed-size input message into the block using ordinary AXI4 write bursts. The block keeps the message in a local buffer and presents every byte of it to the kernel in parallel, as 32-bit little-endian words. It raises a kernel-valid flag once the last byte of the message has been written.

The kernel hands back a fixed-size result with a strobe. The block captures that result into an outgoing buffer only while the input message is complete, and it marks the outgoing buffer valid when it does. The host then collects the result with AXI4 read bursts on the same port.

Writes and reads run independently, one transaction per direction at a time, with incrementing bursts of full bus width. Both buffer sizes and the bus width must be powers of two. The bus carries at least 32 bits, and each buffer spans at least two beats.

Top module: `kmsg_mailbox`

## Requirements
- R1: A write burst whose address handshake carries byte offset A stores beat i at byte offsets A+i*BEAT_BYTES onward, with lane j of the beat going to the byte one higher than lane j-1. Offsets wrap modulo the message size, and addresses must be beat aligned.
- R2: `kern_data_o` presents the whole message at once: byte offset n appears at bits 8n+7..8n, so kernel word k holds bytes 4k..4k+3 with byte 4k in its least significant position.
- R3: Within an accepted write beat (WVALID and WREADY both high), only the bytes whose WSTRB bit is 1 change; the other message bytes keep their values.
- R4: After the beat carrying WLAST is accepted, BVALID rises with BRESP = 2'b00 (OKAY) and BID equal to the burst's AWID, and both stay put until BREADY is high. AWREADY stays low from the address handshake until that response completes, and AWREADY and WREADY are never high together.
- R5: `kern_valid_o` becomes 1 in the cycle after a beat is accepted that covers the message's final byte offset with that byte's strobe bit set. No other event sets it.
- R6: A write address handshake at byte offset 0 starts a new message and clears both `kern_valid_o` and `out_valid_o` on the next cycle. Bursts that start at any other offset leave both flags as they were.
- R7: When `res_valid_i` is high while `kern_valid_o` is high, `res_data_i` is copied into the outgoing buffer and `out_valid_o` is set. When `res_valid_i` is high while `kern_valid_o` is low, both the buffer and `out_valid_o` are left unchanged.
- R8: A read address handshake with offset A and length ARLEN returns ARLEN+1 beats of the outgoing buffer, starting at beat A/BEAT_BYTES and rising by one beat each time (wrapping at the buffer size). Each beat has RRESP = 2'b00 and RID = ARID, and RLAST is 1 on the final beat only.
- R9: While RVALID is high and RREADY is low, RVALID, RDATA, RLAST and RID hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | ADDR_W | Write burst start byte offset |
| awlen_i | input | 8 | Write burst length minus one |
| awid_i | input | ID_W | Write transaction ID |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | DATA_W | Write data beat |
| wstrb_i | input | DATA_W/8 | Byte strobes of the beat |
| wlast_i | input | 1 | Final beat of the burst |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bid_o | output | ID_W | Response ID |
| bresp_o | output | 2 | Write response code |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | RADDR_W | Read burst start byte offset |
| arlen_i | input | 8 | Read burst length minus one |
| arid_i | input | ID_W | Read transaction ID |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rid_o | output | ID_W | Read data ID |
| rdata_o | output | DATA_W | Read data beat |
| rresp_o | output | 2 | Read response code |
| rlast_o | output | 1 | Final read beat |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| kern_data_o | output | 8*MSG_BYTES | Whole input message to the kernel |
| kern_valid_o | output | 1 | Input message complete |
| res_data_i | input | 8*RES_BYTES | Kernel result |
| res_valid_i | input | 1 | Kernel result strobe |
| out_valid_o | output | 1 | Outgoing buffer holds a captured result |

## Verification
Several protocol rules are checked by assertions on every cycle: the write response and the read beat hold steady while stalled, the two write-side ready signals never overlap, addresses are beat aligned, the valid flags rise only after a qualifying write or capture, and an offset-0 address handshake clears both flags on the next cycle. The assertions cannot show that the stored bytes are correct. Only the bench scenarios can show byte placement and little-endian word order, strobe masking, that a result offered before the message completes is dropped while the earlier buffer survives, and that read data comes back in the right order with RLAST on the right beat.

// File: rtl/kmsg_pkg.sv
package kmsg_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    WR_ADDR,
    WR_DATA,
    WR_RESP
  } wr_state_e;

  typedef enum logic {
    RD_ADDR,
    RD_DATA
  } rd_state_e;
endpackage

// File: rtl/kmsg_wr_ctrl.sv
module kmsg_wr_ctrl
  import kmsg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   awaddr_i,
  input  logic [ID_W-1:0]     awid_i,
  input  logic                awvalid_i,
  output logic                awready_o,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W/8-1:0] wstrb_i,
  input  logic                wlast_i,
  input  logic                wvalid_i,
  output logic                wready_o,
  output logic [ID_W-1:0]     bid_o,
  output logic [1:0]          bresp_o,
  output logic                bvalid_o,
  input  logic                bready_i,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [DATA_W/8-1:0] wr_strb_o,
  output logic                new_msg_o
);
  wr_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic [ID_W-1:0]  id_q;
  logic aw_hs, w_hs;

  assign awready_o = (state_q == WR_ADDR);
  assign wready_o  = (state_q == WR_DATA);
  assign bvalid_o  = (state_q == WR_RESP);
  assign bid_o     = id_q;
  assign bresp_o   = RESP_OKAY;
  assign aw_hs     = awvalid_i && awready_o;
  assign w_hs      = wvalid_i && wready_o;

  assign wr_en_o   = w_hs;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = wdata_i;
  assign wr_strb_o = wstrb_i;
  assign new_msg_o = aw_hs && (awaddr_i[OFF +: IDX_W] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_ADDR;
      idx_q   <= '0;
      id_q    <= '0;
    end else begin
      unique case (state_q)
        WR_ADDR: if (aw_hs) begin
          idx_q   <= awaddr_i[OFF +: IDX_W];
          id_q    <= awid_i;
          state_q <= WR_DATA;
        end
        WR_DATA: if (w_hs) begin
          idx_q <= idx_q + 1'b1;  // wraps at message size
          if (wlast_i) state_q <= WR_RESP;
        end
        WR_RESP: if (bready_i) state_q <= WR_ADDR;
        default: state_q <= WR_ADDR;
      endcase
    end
  end

  assert_aw_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_hs |-> (awaddr_i[OFF-1:0] == '0));

  assert_b_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> (bvalid_o && $stable(bid_o) && bresp_o == RESP_OKAY));

  assert_ready_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(awready_o && wready_o));
endmodule

// File: rtl/kmsg_store.sv
module kmsg_store #(
  parameter int DATA_W    = 32,
  parameter int MSG_BEATS = 1024,
  parameter int IDX_W     = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [DATA_W/8-1:0]         wr_strb_i,
  input  logic                        new_msg_i,
  output logic [MSG_BEATS*DATA_W-1:0] kern_data_o,
  output logic                        msg_valid_o
);
  localparam int LANES = DATA_W / 8;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_BEATS - 1);

  logic [DATA_W-1:0] mem_q [MSG_BEATS];
  logic msg_valid_q;
  logic final_byte;

  // Payload storage carries no reset; only the flag does.
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_strb_i[l]) mem_q[wr_idx_i][l*8 +: 8] <= wr_data_i[l*8 +: 8];
      end
    end
  end

  for (genvar b = 0; b < MSG_BEATS; b++) begin : g_flat
    assign kern_data_o[b*DATA_W +: DATA_W] = mem_q[b];
  end

  assign final_byte = wr_en_i && (wr_idx_i == LAST_IDX) && wr_strb_i[LANES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         msg_valid_q <= 1'b0;
    else if (new_msg_i)  msg_valid_q <= 1'b0;
    else if (final_byte) msg_valid_q <= 1'b1;
  end

  assign msg_valid_o = msg_valid_q;

  assert_valid_needs_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_q) |-> $past(wr_en_i && wr_strb_i[LANES-1]));

  assert_new_msg_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_msg_i |=> !msg_valid_q);
endmodule

// File: rtl/kmsg_rd_ctrl.sv
module kmsg_rd_ctrl
  import kmsg_pkg::*;
#(
  parameter int RADDR_W   = 4,
  parameter int ID_W      = 4,
  parameter int DATA_W    = 32,
  parameter int RES_BEATS = 4,
  parameter int RIDX_W    = 2,
  parameter int OFF       = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [RADDR_W-1:0]          araddr_i,
  input  logic [7:0]                  arlen_i,
  input  logic [ID_W-1:0]             arid_i,
  input  logic                        arvalid_i,
  output logic                        arready_o,
  output logic [ID_W-1:0]             rid_o,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [1:0]                  rresp_o,
  output logic                        rlast_o,
  output logic                        rvalid_o,
  input  logic                        rready_i,
  input  logic [RES_BEATS*DATA_W-1:0] res_data_i,
  input  logic                        res_valid_i,
  input  logic                        msg_valid_i,
  input  logic                        new_msg_i,
  output logic                        out_valid_o
);
  rd_state_e state_q;
  logic [RIDX_W-1:0] idx_q;
  logic [7:0]        cnt_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] res_q [RES_BEATS];
  logic out_valid_q;
  logic capture, ar_hs, r_hs;

  assign capture = res_valid_i && msg_valid_i;

  always_ff @(posedge clk_i) begin
    if (capture) begin
      for (int b = 0; b < RES_BEATS; b++) res_q[b] <= res_data_i[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        out_valid_q <= 1'b0;
    else if (new_msg_i) out_valid_q <= 1'b0;
    else if (capture)   out_valid_q <= 1'b1;
  end

  assign out_valid_o = out_valid_q;
  assign arready_o   = (state_q == RD_ADDR);
  assign rvalid_o    = (state_q == RD_DATA);
  assign rdata_o     = res_q[idx_q];
  assign rlast_o     = rvalid_o && (cnt_q == 8'd0);
  assign rid_o       = id_q;
  assign rresp_o     = RESP_OKAY;
  assign ar_hs       = arvalid_i && arready_o;
  assign r_hs        = rvalid_o && rready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_ADDR;
      idx_q   <= '0;
      cnt_q   <= '0;
      id_q    <= '0;
    end else begin
      unique case (state_q)
        RD_ADDR: if (ar_hs) begin
          idx_q   <= araddr_i[OFF +: RIDX_W];
          cnt_q   <= arlen_i;
          id_q    <= arid_i;
          state_q <= RD_DATA;
        end
        RD_DATA: if (r_hs) begin
          idx_q <= idx_q + 1'b1;
          cnt_q <= cnt_q - 8'd1;
          if (cnt_q == 8'd0) state_q <= RD_ADDR;
        end
        default: state_q <= RD_ADDR;
      endcase
    end
  end

  assert_ar_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_hs |-> (araddr_i[OFF-1:0] == '0));

  assert_r_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rlast_o) && $stable(rid_o)));

  assert_capture_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_q) |-> $past(res_valid_i && msg_valid_i));

  assert_out_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_msg_i |=> !out_valid_q);
endmodule

// File: rtl/kmsg_mailbox.sv
module kmsg_mailbox #(
  parameter int DATA_W    = 32,
  parameter int MSG_BYTES = 4096,
  parameter int RES_BYTES = 16,
  parameter int ID_W      = 4,
  parameter int ADDR_W    = $clog2(MSG_BYTES),
  parameter int RADDR_W   = $clog2(RES_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      awaddr_i,
  input  logic [7:0]             awlen_i,
  input  logic [ID_W-1:0]        awid_i,
  input  logic                   awvalid_i,
  output logic                   awready_o,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [DATA_W/8-1:0]    wstrb_i,
  input  logic                   wlast_i,
  input  logic                   wvalid_i,
  output logic                   wready_o,
  output logic [ID_W-1:0]        bid_o,
  output logic [1:0]             bresp_o,
  output logic                   bvalid_o,
  input  logic                   bready_i,
  input  logic [RADDR_W-1:0]     araddr_i,
  input  logic [7:0]             arlen_i,
  input  logic [ID_W-1:0]        arid_i,
  input  logic                   arvalid_i,
  output logic                   arready_o,
  output logic [ID_W-1:0]        rid_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [1:0]             rresp_o,
  output logic                   rlast_o,
  output logic                   rvalid_o,
  input  logic                   rready_i,
  output logic [8*MSG_BYTES-1:0] kern_data_o,
  output logic                   kern_valid_o,
  input  logic [8*RES_BYTES-1:0] res_data_i,
  input  logic                   res_valid_i,
  output logic                   out_valid_o
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int OFF        = $clog2(BEAT_BYTES);
  localparam int MSG_BEATS  = MSG_BYTES / BEAT_BYTES;
  localparam int RES_BEATS  = RES_BYTES / BEAT_BYTES;
  localparam int IDX_W      = $clog2(MSG_BEATS);
  localparam int RIDX_W     = $clog2(RES_BEATS);

  logic                  wr_en, new_msg;
  logic [IDX_W-1:0]      wr_idx;
  logic [DATA_W-1:0]     wr_data;
  logic [BEAT_BYTES-1:0] wr_strb;

  // awlen is implied by WLAST; it is kept for bus completeness
  logic unused_awlen;
  assign unused_awlen = ^awlen_i;

  kmsg_wr_ctrl #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF(OFF)
  ) i_wr_ctrl (
    .clk_i, .rst_ni,
    .awaddr_i, .awid_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wlast_i, .wvalid_i, .wready_o,
    .bid_o, .bresp_o, .bvalid_o, .bready_i,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .wr_strb_o(wr_strb), .new_msg_o(new_msg)
  );

  kmsg_store #(
    .DATA_W(DATA_W), .MSG_BEATS(MSG_BEATS), .IDX_W(IDX_W)
  ) i_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .new_msg_i(new_msg), .kern_data_o, .msg_valid_o(kern_valid_o)
  );

  kmsg_rd_ctrl #(
    .RADDR_W(RADDR_W), .ID_W(ID_W), .DATA_W(DATA_W),
    .RES_BEATS(RES_BEATS), .RIDX_W(RIDX_W), .OFF(OFF)
  ) i_rd_ctrl (
    .clk_i, .rst_ni,
    .araddr_i, .arlen_i, .arid_i, .arvalid_i, .arready_o,
    .rid_o, .rdata_o, .rresp_o, .rlast_o, .rvalid_o, .rready_i,
    .res_data_i, .res_valid_i, .msg_valid_i(kern_valid_o),
    .new_msg_i(new_msg), .out_valid_o
  );
endmodule

// File: tb/test_kmsg_mailbox.sv
`timescale 1ns/1ps
module test_kmsg_mailbox;
  localparam int DW = 32, MSG = 64, RES = 16, IDW = 4;
  localparam int BEATS = MSG / 4, RBEATS = RES / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [5:0] awaddr = '0; logic [7:0] awlen = '0; logic [IDW-1:0] awid = '0;
  logic awvalid = 0, awready;
  logic [DW-1:0] wdata = '0; logic [3:0] wstrb = '0; logic wlast = 0, wvalid = 0, wready;
  logic [IDW-1:0] bid; logic [1:0] bresp; logic bvalid, bready = 0;
  logic [3:0] araddr = '0; logic [7:0] arlen = '0; logic [IDW-1:0] arid = '0;
  logic arvalid = 0, arready;
  logic [IDW-1:0] rid; logic [DW-1:0] rdata; logic [1:0] rresp; logic rlast, rvalid, rready = 0;
  logic [8*MSG-1:0] kern_data; logic kern_valid;
  logic [8*RES-1:0] res_data = '0; logic res_valid = 0; logic out_valid;

  kmsg_mailbox #(.DATA_W(DW), .MSG_BYTES(MSG), .RES_BYTES(RES), .ID_W(IDW)) i_kmsg_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .awaddr_i(awaddr), .awlen_i(awlen), .awid_i(awid), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wlast_i(wlast), .wvalid_i(wvalid), .wready_o(wready),
    .bid_o(bid), .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .araddr_i(araddr), .arlen_i(arlen), .arid_i(arid), .arvalid_i(arvalid), .arready_o(arready),
    .rid_o(rid), .rdata_o(rdata), .rresp_o(rresp), .rlast_o(rlast), .rvalid_o(rvalid),
    .rready_i(rready), .kern_data_o(kern_data), .kern_valid_o(kern_valid),
    .res_data_i(res_data), .res_valid_i(res_valid), .out_valid_o(out_valid));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]  ref_msg [MSG];
  logic [31:0] beat_d [BEATS];
  logic [3:0]  beat_s [BEATS];
  logic [8*RES-1:0] res_ref;

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8*MSG-1:0] exp_kern();
    logic [8*MSG-1:0] v;
    for (int i = 0; i < MSG; i++) v[8*i +: 8] = ref_msg[i];
    return v;
  endfunction

  task automatic fill(input int n, input logic [7:0] seed, input logic [3:0] strb);
    for (int b = 0; b < n; b++) begin
      beat_d[b] = {seed + 8'(4*b+3), seed + 8'(4*b+2), seed + 8'(4*b+1), seed + 8'(4*b)};
      beat_s[b] = strb;
    end
  endtask

  task automatic do_write(input int start, input int n, input logic [IDW-1:0] id, input int bstall);
    logic s; bit ok;
    @(negedge clk);
    awvalid = 1; awaddr = 6'(start*4); awlen = 8'(n-1); awid = id;
    do begin s = awready; @(posedge clk); end while (!s);
    @(negedge clk); awvalid = 0;
    for (int b = 0; b < n; b++) begin
      wvalid = 1; wdata = beat_d[b]; wstrb = beat_s[b]; wlast = (b == n-1);
      do begin s = wready; @(posedge clk); end while (!s);
      for (int l = 0; l < 4; l++)
        if (beat_s[b][l]) ref_msg[((start+b)*4 + l) % MSG] = beat_d[b][8*l +: 8];
      @(negedge clk);
    end
    wvalid = 0; wlast = 0;
    ok = 1;
    for (int i = 0; i < bstall; i++) begin
      if (!bvalid || bid != id || awready) ok = 0;
      @(negedge clk);
    end
    chk(ok && bvalid, "R4 response held while stalled", 512'(bvalid), 512'(1));
    chk(bresp == 2'b00 && bid == id, "R4 bresp/bid", 512'({bresp, bid}), 512'({2'b00, id}));
    bready = 1; @(posedge clk); @(negedge clk); bready = 0;
    chk(!bvalid && awready, "R4 response done", 512'({bvalid, awready}), 512'(2'b01));
  endtask

  task automatic do_read(input int start, input int n, input logic [IDW-1:0] id, input bit stall);
    logic s; logic [31:0] d0; logic l0; bit ok;
    @(negedge clk);
    arvalid = 1; araddr = 4'(start*4); arlen = 8'(n-1); arid = id;
    do begin s = arready; @(posedge clk); end while (!s);
    @(negedge clk); arvalid = 0;
    if (stall) begin
      d0 = rdata; l0 = rlast; ok = 1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (!rvalid || rdata != d0 || rlast != l0 || rid != id) ok = 0;
      end
      chk(ok, "R9 read beat held while stalled", 512'(rdata), 512'(d0));
    end
    rready = 1;
    for (int b = 0; b < n; b++) begin
      logic [31:0] e;
      e = res_ref[((start+b) % RBEATS)*32 +: 32];
      chk(rvalid && rdata == e, "R8 read data order", 512'(rdata), 512'(e));
      chk(rlast == (b == n-1) && rid == id && rresp == 2'b00, "R8 rlast/rid/rresp",
          512'({rlast, rid, rresp}), 512'({(b == n-1), id, 2'b00}));
      @(negedge clk);
    end
    rready = 0;
    chk(!rvalid && arready, "R8 burst ends", 512'(rvalid), 512'(0));
  endtask

  task automatic give_result(input logic [8*RES-1:0] v);
    @(negedge clk); res_data = v; res_valid = 1;
    @(negedge clk); res_valid = 0;
  endtask

  task automatic t_reset();
    chk(awready && arready && !wready && !bvalid && !rvalid, "reset handshake state",
        512'({awready, arready, wready, bvalid, rvalid}), 512'(5'b11000));
    chk(!kern_valid && !out_valid, "R5 R7 reset flags", 512'({kern_valid, out_valid}), 512'(0));
  endtask

  task automatic t_full_write();
    fill(BEATS, 8'h10, 4'hF);
    do_write(0, BEATS, 4'd3, 3);
    chk(kern_data == exp_kern(), "R1 R2 full message layout", 512'(kern_data), 512'(exp_kern()));
    chk(kern_data[31:0] == 32'h13121110, "R2 little-endian word 0", 512'(kern_data[31:0]), 512'h13121110);
    chk(kern_valid, "R5 valid after final byte", 512'(kern_valid), 512'(1));
  endtask

  task automatic t_strobes();
    fill(3, 8'hA0, 4'b0101);
    beat_s[1] = 4'b1000; beat_s[2] = 4'b0000;
    do_write(5, 3, 4'd6, 0);
    chk(kern_data == exp_kern(), "R3 strobe masking", 512'(kern_data), 512'(exp_kern()));
    chk(kern_valid, "R6 nonzero start keeps valid", 512'(kern_valid), 512'(1));
  endtask

  task automatic t_result_read();
    res_ref = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    give_result(res_ref);
    chk(out_valid, "R7 capture sets out_valid", 512'(out_valid), 512'(1));
    do_read(0, RBEATS, 4'd9, 1);
  endtask

  task automatic t_new_message();
    fill(8, 8'h40, 4'hF);
    do_write(0, 8, 4'd1, 1);
    chk(!kern_valid && !out_valid, "R6 offset-0 start clears flags",
        512'({kern_valid, out_valid}), 512'(0));
    give_result(128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF);
    chk(!out_valid, "R7 result ignored while incomplete", 512'(out_valid), 512'(0));
    do_read(0, RBEATS, 4'd2, 0);  // still the earlier result
    fill(8, 8'h80, 4'hF);
    beat_s[7] = 4'b0111;
    do_write(8, 8, 4'd4, 0);
    chk(!kern_valid, "R5 final byte strobed off", 512'(kern_valid), 512'(0));
    fill(1, 8'hC0, 4'b1000);
    do_write(15, 1, 4'd5, 0);
    chk(kern_valid, "R5 final byte alone sets valid", 512'(kern_valid), 512'(1));
    chk(kern_data == exp_kern(), "R1 R3 assembled across bursts", 512'(kern_data), 512'(exp_kern()));
    res_ref = 128'h55443322_11FFEEDD_CCBBAA99_88776655;
    give_result(res_ref);
    chk(out_valid, "R7 capture after completion", 512'(out_valid), 512'(1));
    do_read(2, 2, 4'd7, 1);
    do_read(3, 2, 4'd8, 0);  // wraps to beat 0
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MSG; i++) ref_msg[i] = '0;
    res_ref = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_write();
    t_strobes();
    t_result_read();
    t_new_message();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule